// File: doc/BRIEF.md
# Per-Task Scratch Register Bank Selector

This block holds a small bank number for every microcode task and uses the bank of the task that is running to widen the address of a shared scratch register file. Each cycle it receives the running task identifier, the 4-bit F1 function field of the microinstruction, a strobe that marks the function as valid, a data value carrying a new bank number, and the 5-bit register index. It returns the running task's bank number and the register-file address formed from that bank and the index.

Two F1 codes are decoded, and their meaning depends on the task and on a build-time option. With the extended control-RAM option present, the emulator task (task 0) loads its bank with code 15 (octal), while every other RAM-related task loads its own bank with code 13 (octal). The emulator treats code 13 as a reset-mode-register request and raises a strobe for it. Without the option, code 13 is that request in every RAM-related task and no bank ever changes. Tasks that are not RAM-related ignore both codes and always read bank 0. Reset returns all tasks to bank 0, so they share one bank until software gives them others.

Top module: `reg_bank_sel`

## Requirements
- R1: With the option present, strobe high, task 0 and F1 = 15 (octal) write data_i into task 0's bank; the new value is on bank_o from the next cycle in which task 0 runs.
- R2: With the option present, strobe high, a RAM-related task other than 0 and F1 = 13 (octal) write data_i into that task's bank from the next cycle.
- R3: With the option present, strobe high, task 0 and F1 = 13 (octal) raise rst_mode_o in that same cycle and leave task 0's bank unchanged.
- R4: rst_mode_o is high only in a cycle with strobe high and F1 = 13 (octal); F1 = 15 (octal) in a task other than 0 changes no bank and raises no strobe.
- R5: With the option absent, strobe high, a RAM-related task and F1 = 13 (octal) raise rst_mode_o, and no code changes any bank (all banks read 0).
- R6: An active-low reset clears the bank of every task to 0.
- R7: rf_addr_o equals {bank of task_i, reg_idx_i}, bank in the upper 3 bits, combinationally from task_i and reg_idx_i.
- R8: A task whose bit in RAM_TASK_MASK is 0 (tasks 8 to 15 by default) ignores both codes: bank_o stays 0 and rst_mode_o stays low.
- R9: With strobe low, neither code changes any bank or raises rst_mode_o.
- R10: A load changes only the bank of the issuing task.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| task_i | input | 4 | Running task identifier |
| f1_i | input | 4 | F1 function field |
| strobe_i | input | 1 | F1 field valid this cycle |
| data_i | input | 3 | New bank number |
| reg_idx_i | input | 5 | Scratch register index |
| bank_o | output | 3 | Bank of the running task |
| rf_addr_o | output | 8 | Scratch register file address |
| rst_mode_o | output | 1 | Reset-mode-register request |

## Verification
The load-visibility property assumes task_i stays the same across the cycle after a load when it compares bank_o with the loaded value; if the task changes, the property makes no claim, so the stimulus repeats the issuing task on the following vector to exercise it. All properties assume task_i, f1_i, strobe_i and data_i are known and settled at each rising edge, which the bench ensures by driving them only on the falling edge. A second instance built without the option shares the same inputs, so the same vectors also exercise the option-absent decode.

// File: rtl/rbs_pkg.sv
package rbs_pkg;
  localparam int F1_W = 4;
  localparam logic [F1_W-1:0] F1_EMU_BANK  = 4'o15;
  localparam logic [F1_W-1:0] F1_TASK_BANK = 4'o13;

  typedef struct packed {
    logic load;
    logic rst_mode;
  } f1_act_t;
endpackage

// File: rtl/rbs_decode.sv
module rbs_decode
  import rbs_pkg::*;
#(
  parameter int NUM_TASKS = 16,
  parameter int EMU_TASK = 0,
  parameter logic [NUM_TASKS-1:0] RAM_TASK_MASK = '1,
  parameter bit EXT_RAM = 1'b1,
  localparam int TASK_W = $clog2(NUM_TASKS)
) (
  input  logic [TASK_W-1:0] task_i,
  input  logic [F1_W-1:0]   f1_i,
  input  logic              strobe_i,
  output f1_act_t           act_o
);
  logic is_ram, is_emu;
  assign is_ram = RAM_TASK_MASK[task_i];
  assign is_emu = (task_i == TASK_W'(EMU_TASK));

  generate
    if (EXT_RAM) begin : g_ext
      always_comb begin
        act_o.load = strobe_i && is_ram &&
                     ((is_emu && f1_i == F1_EMU_BANK) ||
                      (!is_emu && f1_i == F1_TASK_BANK));
        act_o.rst_mode = strobe_i && is_ram && is_emu && f1_i == F1_TASK_BANK;
      end
    end else begin : g_base
      always_comb begin
        act_o.load     = 1'b0;
        act_o.rst_mode = strobe_i && is_ram && f1_i == F1_TASK_BANK;
      end
    end
  endgenerate
endmodule

// File: rtl/rbs_store.sv
module rbs_store #(
  parameter int NUM_TASKS = 16,
  parameter int BANK_W = 3,
  parameter logic [NUM_TASKS-1:0] RAM_TASK_MASK = '1,
  localparam int TASK_W = $clog2(NUM_TASKS)
) (
  input  logic                              clk_i,
  input  logic                              rst_ni,
  input  logic                              load_i,
  input  logic [TASK_W-1:0]                 task_i,
  input  logic [BANK_W-1:0]                 data_i,
  output logic [NUM_TASKS-1:0][BANK_W-1:0]  bank_o
);
  for (genvar g = 0; g < NUM_TASKS; g++) begin : g_task
    if (RAM_TASK_MASK[g]) begin : g_ram
      logic [BANK_W-1:0] bank_q;
      always_ff @(posedge clk_i or negedge rst_ni) begin
        if (!rst_ni) bank_q <= '0;
        else if (load_i && task_i == TASK_W'(g)) bank_q <= data_i;
      end
      assign bank_o[g] = bank_q;
    end else begin : g_fixed
      assign bank_o[g] = '0;
    end
  end
endmodule

// File: rtl/rbs_addr.sv
module rbs_addr #(
  parameter int NUM_TASKS = 16,
  parameter int BANK_W = 3,
  parameter int IDX_W = 5,
  localparam int TASK_W = $clog2(NUM_TASKS)
) (
  input  logic [NUM_TASKS-1:0][BANK_W-1:0] bank_i,
  input  logic [TASK_W-1:0]                task_i,
  input  logic [IDX_W-1:0]                 reg_idx_i,
  output logic [BANK_W-1:0]                bank_o,
  output logic [BANK_W+IDX_W-1:0]          rf_addr_o
);
  assign bank_o    = bank_i[task_i];
  assign rf_addr_o = {bank_o, reg_idx_i};
endmodule

// File: rtl/reg_bank_sel.sv
module reg_bank_sel
  import rbs_pkg::*;
#(
  parameter int NUM_TASKS = 16,
  parameter int BANK_W = 3,
  parameter int IDX_W = 5,
  parameter int EMU_TASK = 0,
  parameter logic [NUM_TASKS-1:0] RAM_TASK_MASK = 16'h00FF,
  parameter bit EXT_RAM = 1'b1,
  localparam int TASK_W = $clog2(NUM_TASKS)
) (
  input  logic                    clk_i,
  input  logic                    rst_ni,
  input  logic [TASK_W-1:0]       task_i,
  input  logic [F1_W-1:0]         f1_i,
  input  logic                    strobe_i,
  input  logic [BANK_W-1:0]       data_i,
  input  logic [IDX_W-1:0]        reg_idx_i,
  output logic [BANK_W-1:0]       bank_o,
  output logic [BANK_W+IDX_W-1:0] rf_addr_o,
  output logic                    rst_mode_o
);
  f1_act_t act;
  logic [NUM_TASKS-1:0][BANK_W-1:0] banks;

  rbs_decode #(
    .NUM_TASKS(NUM_TASKS), .EMU_TASK(EMU_TASK),
    .RAM_TASK_MASK(RAM_TASK_MASK), .EXT_RAM(EXT_RAM)
  ) u_decode (
    .task_i(task_i), .f1_i(f1_i), .strobe_i(strobe_i), .act_o(act)
  );

  rbs_store #(
    .NUM_TASKS(NUM_TASKS), .BANK_W(BANK_W), .RAM_TASK_MASK(RAM_TASK_MASK)
  ) u_store (
    .clk_i(clk_i), .rst_ni(rst_ni), .load_i(act.load),
    .task_i(task_i), .data_i(data_i), .bank_o(banks)
  );

  rbs_addr #(
    .NUM_TASKS(NUM_TASKS), .BANK_W(BANK_W), .IDX_W(IDX_W)
  ) u_addr (
    .bank_i(banks), .task_i(task_i), .reg_idx_i(reg_idx_i),
    .bank_o(bank_o), .rf_addr_o(rf_addr_o)
  );

  assign rst_mode_o = act.rst_mode;
endmodule

// File: rtl/rbs_chk.sv
module rbs_chk
  import rbs_pkg::*;
#(
  parameter int NUM_TASKS = 16,
  parameter int BANK_W = 3,
  parameter int EMU_TASK = 0,
  parameter logic [NUM_TASKS-1:0] RAM_TASK_MASK = 16'h00FF,
  parameter bit EXT_RAM = 1'b1,
  localparam int TASK_W = $clog2(NUM_TASKS)
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic [TASK_W-1:0] task_i,
  input logic [F1_W-1:0]   f1_i,
  input logic              strobe_i,
  input logic [BANK_W-1:0] data_i,
  input logic [BANK_W-1:0] bank_o,
  input logic              rst_mode_o
);
  // R1
  emu_load_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (EXT_RAM && strobe_i && task_i == TASK_W'(EMU_TASK) && f1_i == F1_EMU_BANK)
    |=> (task_i != $past(task_i) || bank_o == $past(data_i)));

  // R3
  emu_rst_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (EXT_RAM && strobe_i && task_i == TASK_W'(EMU_TASK) && f1_i == F1_TASK_BANK)
    |-> rst_mode_o);

  // R4
  rst_mode_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rst_mode_o |-> (strobe_i && f1_i == F1_TASK_BANK));

  // R5
  base_rst_mode_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!EXT_RAM && strobe_i && RAM_TASK_MASK[task_i] && f1_i == F1_TASK_BANK)
    |-> rst_mode_o);

  // R5
  base_no_bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !EXT_RAM |-> bank_o == '0);

  // R8
  plain_task_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !RAM_TASK_MASK[task_i] |-> (bank_o == '0 && !rst_mode_o));
endmodule

bind reg_bank_sel rbs_chk #(
  .NUM_TASKS(NUM_TASKS), .BANK_W(BANK_W), .EMU_TASK(EMU_TASK),
  .RAM_TASK_MASK(RAM_TASK_MASK), .EXT_RAM(EXT_RAM)
) chk_i (
  .clk_i(clk_i), .rst_ni(rst_ni), .task_i(task_i), .f1_i(f1_i),
  .strobe_i(strobe_i), .data_i(data_i), .bank_o(bank_o),
  .rst_mode_o(rst_mode_o)
);

// File: tb/reg_bank_sel_tb_top.sv
`timescale 1ns/1ps
module reg_bank_sel_tb_top;
  // vector: task4 f1 4 stb1 data3 idx5 exp_bank3 exp_rst1 = 21 bits
  function automatic logic [20:0] mk(input logic [3:0] t, input logic [3:0] f,
      input logic s, input logic [2:0] d, input logic [4:0] i,
      input logic [2:0] eb, input logic er);
    return {t, f, s, d, i, eb, er};
  endfunction

  localparam int NV = 16;
  localparam logic [20:0] VEC [NV] = '{
    mk(4'd0, 4'o15, 1, 3'd5, 5'd3,  3'd0, 0), // R1 load emu
    mk(4'd0, 4'o00, 0, 3'd0, 5'd7,  3'd5, 0), // R1 visible
    mk(4'd0, 4'o13, 1, 3'd2, 5'd1,  3'd5, 1), // R3 strobe
    mk(4'd0, 4'o00, 0, 3'd0, 5'd2,  3'd5, 0), // R3 no load
    mk(4'd3, 4'o13, 1, 3'd6, 5'd4,  3'd0, 0), // R2 load task 3
    mk(4'd3, 4'o00, 0, 3'd0, 5'd9,  3'd6, 0), // R2 visible
    mk(4'd0, 4'o00, 0, 3'd0, 5'd0,  3'd5, 0), // R10 isolation
    mk(4'd3, 4'o15, 1, 3'd1, 5'd5,  3'd6, 0), // R4 code 15 non-emu
    mk(4'd3, 4'o00, 0, 3'd0, 5'd6,  3'd6, 0), // R4 unchanged
    mk(4'd3, 4'o13, 0, 3'd2, 5'd8,  3'd6, 0), // R9 no strobe
    mk(4'd3, 4'o00, 0, 3'd0, 5'd10, 3'd6, 0), // R9 unchanged
    mk(4'd9, 4'o13, 1, 3'd7, 5'd11, 3'd0, 0), // R8 ignored
    mk(4'd9, 4'o15, 1, 3'd7, 5'd12, 3'd0, 0), // R8 ignored
    mk(4'd9, 4'o00, 0, 3'd0, 5'd13, 3'd0, 0), // R8 still 0
    mk(4'd7, 4'o13, 1, 3'd7, 5'd31, 3'd0, 0), // R2 load task 7
    mk(4'd7, 4'o00, 0, 3'd0, 5'd31, 3'd7, 0)  // R7 addr FF
  };

  logic clk = 1'b0, rst_n = 1'b0;
  logic [3:0] task_id = '0, f1 = '0;
  logic strobe = 1'b0;
  logic [2:0] data = '0;
  logic [4:0] idx = '0;
  logic [2:0] bank_a, bank_b;
  logic [7:0] addr_a, addr_b;
  logic rst_a, rst_b;
  int checks = 0, errors = 0;
  bit done = 1'b0;

  always #2 clk = ~clk;

  reg_bank_sel dut_i (
    .clk_i(clk), .rst_ni(rst_n), .task_i(task_id), .f1_i(f1), .strobe_i(strobe),
    .data_i(data), .reg_idx_i(idx), .bank_o(bank_a), .rf_addr_o(addr_a),
    .rst_mode_o(rst_a)
  );

  reg_bank_sel #(.EXT_RAM(1'b0)) dut_b_i (
    .clk_i(clk), .rst_ni(rst_n), .task_i(task_id), .f1_i(f1), .strobe_i(strobe),
    .data_i(data), .reg_idx_i(idx), .bank_o(bank_b), .rf_addr_o(addr_b),
    .rst_mode_o(rst_b)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic drive(input logic [3:0] t, input logic [3:0] f, input logic s,
                       input logic [2:0] d, input logic [4:0] i);
    @(negedge clk);
    task_id = t; f1 = f; strobe = s; data = d; idx = i;
    #1;
  endtask

  task automatic finish_run();
    if (!done) begin
      done = 1'b1;
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  endtask

  initial begin
    #100000;
    errors++;
    $display("FAIL watchdog actual 1 expected 0");
    finish_run();
  end

  initial begin
    repeat (3) @(negedge clk);
    #1;
    chk("R6 reset bank", {5'd0, bank_a}, 8'd0);
    chk("R6 reset strobe", {7'd0, rst_a}, 8'd0);
    rst_n = 1'b1;

    for (int n = 0; n < NV; n++) begin
      logic [20:0] v;
      v = VEC[n];
      drive(v[20:17], v[16:13], v[12], v[11:9], v[8:4]);
      chk($sformatf("R7 vec %0d addr", n), addr_a, {v[3:1], v[8:4]});
      chk($sformatf("R4 vec %0d rst_mode", n), {7'd0, rst_a}, {7'd0, v[0]});
    end

    // R6: asynchronous reset clears loaded banks
    @(negedge clk);
    rst_n = 1'b0;
    drive(4'd0, 4'o00, 0, 3'd0, 5'd0);
    chk("R6 task0 cleared", {5'd0, bank_a}, 8'd0);
    drive(4'd3, 4'o00, 0, 3'd0, 5'd0);
    chk("R6 task3 cleared", {5'd0, bank_a}, 8'd0);
    drive(4'd7, 4'o00, 0, 3'd0, 5'd2);
    chk("R6 task7 cleared", addr_a, 8'h02);
    rst_n = 1'b1;

    // R5: option absent
    drive(4'd0, 4'o13, 1, 3'd4, 5'd0);
    chk("R5 emu code13 strobe", {7'd0, rst_b}, 8'd1);
    drive(4'd0, 4'o15, 1, 3'd4, 5'd0);
    chk("R5 emu code15 no strobe", {7'd0, rst_b}, 8'd0);
    drive(4'd0, 4'o00, 0, 3'd0, 5'd1);
    chk("R5 emu bank unchanged", addr_b, 8'h01);
    chk("R1 option present emu load", addr_a, 8'h81);
    drive(4'd3, 4'o13, 1, 3'd6, 5'd0);
    chk("R5 task3 code13 strobe", {7'd0, rst_b}, 8'd1);
    chk("R2 option present no strobe", {7'd0, rst_a}, 8'd0);
    drive(4'd3, 4'o00, 0, 3'd0, 5'd0);
    chk("R5 task3 bank unchanged", {5'd0, bank_b}, 8'd0);
    chk("R2 option present task3 load", {5'd0, bank_a}, 8'd6);
    drive(4'd12, 4'o13, 1, 3'd6, 5'd0);
    chk("R8 option absent plain task", {7'd0, rst_b}, 8'd0);

    drive(4'd0, 4'o00, 0, 3'd0, 5'd0);
    finish_run();
  end
endmodule